// File: doc/BRIEF.md
# Block-Aware Luma Coring Noise Reducer

This block processes a stream of 8-bit luma pixels, one per beat, each tagged with start-of-line and end-of-line markers. For every pixel it takes a small horizontal high-pass of the pixel and its two neighbours, and compares the magnitude of that detail term against a programmable threshold. A single mode bit picks one of two behaviours. In denoise mode, detail below the threshold is treated as noise and a scaled copy of it is removed. In sharpen mode, detail above the threshold is treated as real edge content and a scaled copy of it is added back.

The amount removed or added comes from one of two 4-bit gains. The block tracks where each pixel falls on a compression block grid of 8 or 16 pixels, which can be shifted by a programmable offset. Pixels in a narrow band around each block seam use the border gain, and all other pixels use the data gain. Configuration inputs are static while pixels are in flight.

Both stream ports use valid/ready handshakes. A beat moves when valid and ready are high at a rising edge. The source must hold `in_valid` and the input fields steady until the beat is accepted. When the sink holds `out_ready` low, the output beat stays frozen and `in_ready` drops in the same cycle. The pipeline stalls as a whole and loses nothing. The block also inserts one idle input cycle after each end-of-line beat, which it uses to emit the final pixel of the line.

Top module: `luma_coring_nr`

## Requirements
- R1: In the first cycle after `rst` is released, `out_valid` is 0 and `in_ready` is 1.
- R2: The detail term is d = floor((2c - l - r) / 4), where c is the pixel, l is its left neighbour and r is its right neighbour. |d| is compared with `cfg_threshold`.
- R3: With `cfg_sharpen`=0 and |d| < threshold, the output is c - floor(g·d/8). Otherwise the output is c. Here g is the selected 4-bit gain.
- R4: With `cfg_sharpen`=1 and |d| > threshold, the output is c + floor(g·d/8). Otherwise the output is c.
- R5: Every result is clamped to the range 0..255.
- R6: The first pixel of a line uses itself as its left neighbour, and the last pixel uses itself as its right neighbour. A beat carrying both markers is a one-pixel line, and its output equals its input.
- R7: The position p counts accepted pixels from 0 at the start-of-line beat. The grid phase is (p + `cfg_offset`) mod B, where B is 16 if `cfg_blk16`=1 and 8 otherwise.
- R8: Let h = 2 if `cfg_border4`=1 and h = 1 otherwise. A pixel whose phase is < h or ≥ B - h uses `cfg_gain_border`. All other pixels use `cfg_gain_data`.
- R9: A gain of 0 leaves the pixel unchanged even when the mode's threshold rule applies.
- R10: While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_data` hold and `in_ready` is 0. Outputs leave in input order, exactly one per accepted pixel.
- R11: A pixel that is not last in its line appears on the output one edge after its right neighbour is accepted. The last pixel of a line appears two edges after its own acceptance. `in_ready` is 0 in the cycle after an end-of-line beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_threshold | input | 8 | Noise/detail threshold on \|d\| |
| cfg_gain_data | input | 4 | Gain in eighths away from block seams |
| cfg_gain_border | input | 4 | Gain in eighths inside the seam band |
| cfg_sharpen | input | 1 | 0 = denoise mode, 1 = sharpen mode |
| cfg_blk16 | input | 1 | Grid pitch: 0 = 8 pixels, 1 = 16 pixels |
| cfg_border4 | input | 1 | Seam band width: 0 = 2 pixels, 1 = 4 pixels |
| cfg_offset | input | 4 | Grid phase shift in pixels |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted when high with in_valid |
| in_sol | input | 1 | Beat is the first pixel of a line |
| in_eol | input | 1 | Beat is the last pixel of a line |
| in_data | input | 8 | Luma pixel |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink accepts the output beat |
| out_data | output | 8 | Processed luma pixel |

## Verification
A pixel's result depends on its right neighbour. The output is therefore due one edge after that neighbour's acceptance, or two edges after acceptance for an end-of-line pixel. In runs with `out_ready` held high, the bench records the edge count of every acceptance and compares each output's arrival edge against that rule. Under random back-pressure and input gaps, the bench does not try to predict cycle timing. Instead it compares each transferred output, in order, with a per-pixel expected queue. It also checks that a stalled beat is still present and unchanged one cycle later.

// File: rtl/lcnr_pkg.sv
package lcnr_pkg;

  typedef enum logic {
    MODE_DENOISE = 1'b0,
    MODE_SHARPEN = 1'b1
  } lcnr_mode_e;

endpackage

// File: rtl/lcnr_window.sv
// Holds the pixel awaiting its right neighbour and emits a 3-pixel tap set.
module lcnr_window #(
  parameter int DW = 8,
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          in_valid,
  input  logic          in_sol,
  input  logic          in_eol,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          t_vld,
  output logic [DW-1:0] t_l,
  output logic [DW-1:0] t_c,
  output logic [DW-1:0] t_r,
  output logic [BW-1:0] t_pos
);

  logic          c_vld, c_eol;
  logic [DW-1:0] c_pix, l_pix;
  logic [BW-1:0] c_pos, hcnt;
  logic          flush, take;
  logic [BW-1:0] new_pos;

  // last pixel of a line is emitted in a dedicated cycle with no input
  assign flush    = c_vld && c_eol;
  assign in_ready = en && !flush;
  assign take     = in_valid && in_ready;
  assign new_pos  = in_sol ? '0 : hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      c_vld <= 1'b0;
      c_eol <= 1'b0;
      c_pix <= '0;
      l_pix <= '0;
      c_pos <= '0;
      hcnt  <= '0;
      t_vld <= 1'b0;
      t_l   <= '0;
      t_c   <= '0;
      t_r   <= '0;
      t_pos <= '0;
    end else if (en) begin
      if (flush) begin
        t_vld <= 1'b1;
        t_l   <= l_pix;
        t_c   <= c_pix;
        t_r   <= c_pix;
        t_pos <= c_pos;
        c_vld <= 1'b0;
      end else if (take) begin
        t_vld <= c_vld;
        t_l   <= l_pix;
        t_c   <= c_pix;
        t_r   <= in_data;
        t_pos <= c_pos;
        l_pix <= (in_sol || !c_vld) ? in_data : c_pix;
        c_pix <= in_data;
        c_pos <= new_pos;
        hcnt  <= new_pos + 1'b1;
        c_vld <= 1'b1;
        c_eol <= in_eol;
      end else begin
        t_vld <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/lcnr_grid.sv
// Maps a line position onto the block grid and picks the gain.
module lcnr_grid #(
  parameter int BLK_S = 8,
  parameter int BLK_L = 16,
  parameter int BW    = 4,
  parameter int GW    = 4
) (
  input  logic [BW-1:0] pos,
  input  logic [BW-1:0] offset,
  input  logic          blk16,
  input  logic          border4,
  input  logic [GW-1:0] gain_data,
  input  logic [GW-1:0] gain_border,
  output logic [GW-1:0] gain
);

  logic [BW:0]   pitch, half;
  logic [BW-1:0] mask, phase;
  logic          seam;

  always_comb begin
    pitch = blk16 ? (BW+1)'(BLK_L) : (BW+1)'(BLK_S);
    half  = border4 ? (BW+1)'(2) : (BW+1)'(1);
    mask  = BW'(pitch - 1'b1);
    phase = (pos + offset) & mask;
    seam  = ({1'b0, phase} < half) || ({1'b0, phase} >= (pitch - half));
    gain  = seam ? gain_border : gain_data;
  end

endmodule

// File: rtl/lcnr_core.sv
// High-pass detail term, threshold decision, scaled correction, clamp.
module lcnr_core import lcnr_pkg::*; #(
  parameter int DW    = 8,
  parameter int GW    = 4,
  parameter int GFRAC = 3
) (
  input  logic [DW-1:0] l,
  input  logic [DW-1:0] c,
  input  logic [DW-1:0] r,
  input  logic [GW-1:0] gain,
  input  logic [DW-1:0] thresh,
  input  lcnr_mode_e    mode,
  output logic [DW-1:0] y
);

  localparam int SW  = DW + 3;
  localparam int PRW = SW + GW + 1;
  localparam logic signed [PRW-1:0] TOP = PRW'((1 << DW) - 1);

  logic signed [SW-1:0]  ls, cs, rs, lap, hp;
  logic        [SW-1:0]  mag;
  logic signed [PRW-1:0] hpx, gx, prod, delta, cx, res;
  logic                  is_small, is_large, apply;

  always_comb begin
    ls  = SW'(l);
    cs  = SW'(c);
    rs  = SW'(r);
    lap = (cs <<< 1) - ls - rs;
    hp  = lap >>> 2;
    mag = hp[SW-1] ? SW'(-hp) : SW'(hp);
    is_small = mag < SW'(thresh);
    is_large = mag > SW'(thresh);
    apply = (mode == MODE_SHARPEN) ? is_large : is_small;

    hpx   = PRW'(hp);
    gx    = PRW'(gain);
    prod  = hpx * gx;
    delta = prod >>> GFRAC;
    cx    = PRW'(c);
    if (!apply)                    res = cx;
    else if (mode == MODE_SHARPEN) res = cx + delta;
    else                           res = cx - delta;

    if (res < 0)        y = '0;
    else if (res > TOP) y = TOP[DW-1:0];
    else                y = res[DW-1:0];
  end

endmodule

// File: rtl/luma_coring_nr.sv
module luma_coring_nr import lcnr_pkg::*; #(
  parameter  int DW    = 8,
  parameter  int GW    = 4,
  parameter  int GFRAC = 3,
  parameter  int BLK_S = 8,
  parameter  int BLK_L = 16,
  localparam int BW    = $clog2(BLK_L)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] cfg_threshold,
  input  logic [GW-1:0] cfg_gain_data,
  input  logic [GW-1:0] cfg_gain_border,
  input  logic          cfg_sharpen,
  input  logic          cfg_blk16,
  input  logic          cfg_border4,
  input  logic [BW-1:0] cfg_offset,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_sol,
  input  logic          in_eol,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);

  logic          en;
  logic          t_vld;
  logic [DW-1:0] t_l, t_c, t_r, y;
  logic [BW-1:0] t_pos;
  logic [GW-1:0] gain;

  // whole pipeline advances unless a held output is refused
  assign en = !out_valid || out_ready;

  lcnr_window #(.DW(DW), .BW(BW)) u_win (
    .clk(clk), .rst(rst), .en(en),
    .in_valid(in_valid), .in_sol(in_sol), .in_eol(in_eol), .in_data(in_data),
    .in_ready(in_ready),
    .t_vld(t_vld), .t_l(t_l), .t_c(t_c), .t_r(t_r), .t_pos(t_pos)
  );

  lcnr_grid #(.BLK_S(BLK_S), .BLK_L(BLK_L), .BW(BW), .GW(GW)) u_grid (
    .pos(t_pos), .offset(cfg_offset), .blk16(cfg_blk16), .border4(cfg_border4),
    .gain_data(cfg_gain_data), .gain_border(cfg_gain_border), .gain(gain)
  );

  lcnr_core #(.DW(DW), .GW(GW), .GFRAC(GFRAC)) u_core (
    .l(t_l), .c(t_c), .r(t_r), .gain(gain), .thresh(cfg_threshold),
    .mode(lcnr_mode_e'(cfg_sharpen)), .y(y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (en) begin
      out_valid <= t_vld;
      out_data  <= y;
    end
  end

endmodule

// File: rtl/luma_coring_nr_chk.sv
module luma_coring_nr_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_eol,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data
);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && in_ready));

  a_r10_valid_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  a_r10_data_held: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));

  a_r10_input_blocked: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  a_r11_eol_gap: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eol) |=> !in_ready);

endmodule

bind luma_coring_nr luma_coring_nr_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_eol(in_eol), .out_valid(out_valid), .out_ready(out_ready),
  .out_data(out_data)
);

// File: tb/luma_coring_nr_test.sv
module luma_coring_nr_test;

  localparam int MAXN = 2048;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] thr = 8'd0;
  logic [3:0] gd = 4'd0, gb = 4'd0, off = 4'd0;
  logic       sh = 1'b0, b16 = 1'b0, b4 = 1'b0;
  logic       in_valid = 1'b0, in_sol = 1'b0, in_eol = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic       in_ready, out_valid;
  logic [7:0] out_data;

  int total = 0, bad = 0, edges = 0, n = 0;
  int px[MAXN];
  bit sa[MAXN], ea[MAXN];
  int expv[MAXN], acce[MAXN];

  always #5 clk = ~clk;

  luma_coring_nr uut (
    .clk(clk), .rst(rst), .cfg_threshold(thr), .cfg_gain_data(gd),
    .cfg_gain_border(gb), .cfg_sharpen(sh), .cfg_blk16(b16), .cfg_border4(b4),
    .cfg_offset(off), .in_valid(in_valid), .in_ready(in_ready), .in_sol(in_sol),
    .in_eol(in_eol), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // R7, R8: grid phase and seam band
  function automatic int gain_at(int pos);
    int pitch = b16 ? 16 : 8;
    int h = b4 ? 2 : 1;
    int ph = (pos + int'(off)) % pitch;
    return (ph < h || ph >= pitch - h) ? int'(gb) : int'(gd);
  endfunction

  // R2 to R5: detail term, mode rule, clamp
  function automatic int model(int l, int c, int r, int pos);
    int hp = (2 * c - l - r) >>> 2;
    int mag = hp < 0 ? -hp : hp;
    int d = (hp * gain_at(pos)) >>> 3;
    int res = c;
    if (!sh && mag < int'(thr)) res = c - d;
    if (sh && mag > int'(thr)) res = c + d;
    if (res < 0) res = 0;
    if (res > 255) res = 255;
    return res;
  endfunction

  task automatic add_line(int len, int kind);
    int base = n;
    for (int i = 0; i < len; i++) begin
      case (kind)
        0: px[n] = int'($urandom_range(255));
        1: px[n] = 128 + int'($urandom_range(10)) - 5;
        2: px[n] = (i % 2) ? 255 : 0;
        default: px[n] = (i * 37) % 256;
      endcase
      sa[n] = (i == 0);
      ea[n] = (i == len - 1);
      n++;
    end
    for (int i = 0; i < len; i++) begin
      int li = (i == 0) ? i : i - 1;
      int ri = (i == len - 1) ? i : i + 1;
      expv[base + i] = model(px[base + li], px[base + i], px[base + ri], i);
    end
  endtask

  task automatic drive(string tag, int gap, int stall, bit lat);
    int ii = 0, oi = 0, guard = 0;
    bit hold = 0, prev_stall = 0, take;
    int prev_d = 0;
    while (oi < n && guard < 20000) begin
      @(negedge clk);
      if (prev_stall) begin
        chk("R10 held valid", int'(out_valid), 1);
        chk("R10 held data", int'(out_data), prev_d);
      end
      out_ready = ($urandom_range(99) >= stall);
      if (!hold) begin
        if (ii < n && $urandom_range(99) >= gap) begin
          in_valid = 1'b1;
          in_data  = 8'(px[ii]);
          in_sol   = sa[ii];
          in_eol   = ea[ii];
        end else begin
          in_valid = 1'b0;
        end
      end
      #1;
      if (out_valid && out_ready) begin
        chk(tag, int'(out_data), expv[oi]);
        if (lat) chk("R11 latency", edges, ea[oi] ? acce[oi] + 2 : acce[oi + 1] + 1);
        oi++;
      end
      prev_stall = out_valid && !out_ready;
      prev_d = int'(out_data);
      take = in_valid && in_ready;
      hold = in_valid && !take;
      @(posedge clk);
      edges++;
      guard++;
      if (take) begin
        acce[ii] = edges;
        ii++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    if (oi < n) begin
      total++;
      bad++;
      $display("FAIL %s: stream stalled, got %0d expected %0d outputs", tag, oi, n);
    end
    n = 0;
  endtask

  task automatic setcfg(int t, int g1, int g2, bit s, bit k16, bit k4, int o);
    thr = 8'(t); gd = 4'(g1); gb = 4'(g2); sh = s; b16 = k16; b4 = k4; off = 4'(o);
  endtask

  initial begin
    #1_500_000;
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5a7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk);
    edges = 1;
    @(negedge clk);
    // R1: idle after reset
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 in_ready", int'(in_ready), 1);

    // R2, R3 denoise with two gains, full rate, R11 timing
    setcfg(20, 4, 8, 0, 0, 0, 0);
    for (int k = 0; k < 4; k++) add_line(40, 1);
    add_line(30, 0);
    drive("R2/R3 denoise", 0, 0, 1);

    // R4 sharpen with gaps and back-pressure (R10)
    setcfg(10, 5, 12, 1, 1, 1, 5);
    for (int k = 0; k < 6; k++) add_line(50, k % 2 ? 3 : 0);
    drive("R4/R10 sharpen", 30, 40, 0);

    // R5: alternating extremes drive both clamps
    setcfg(0, 15, 15, 1, 0, 0, 0);
    add_line(20, 2);
    add_line(21, 2);
    drive("R5 clamp", 0, 0, 1);

    // R9: zero gains leave pixels untouched
    setcfg(255, 0, 0, 0, 1, 0, 7);
    for (int k = 0; k < 3; k++) add_line(33, 0);
    drive("R9 zero gain", 10, 10, 0);

    // R6: short lines, one-pixel lines
    setcfg(255, 8, 8, 0, 0, 1, 2);
    for (int k = 0; k < 5; k++) add_line(1, 0);
    for (int k = 0; k < 5; k++) add_line(2, 0);
    add_line(3, 0);
    drive("R6 edges", 20, 20, 0);
    for (int k = 0; k < 4; k++) add_line(1 + k, 0);
    drive("R6 edges timing", 0, 0, 1);

    // R7, R8: only seam pixels are corrected
    setcfg(255, 0, 8, 0, 1, 1, 13);
    for (int k = 0; k < 3; k++) add_line(40, 0);
    drive("R7/R8 grid16", 0, 0, 1);
    setcfg(255, 0, 8, 0, 0, 0, 3);
    for (int k = 0; k < 3; k++) add_line(40, 0);
    drive("R7/R8 grid8", 15, 15, 0);

    // random mix of R3 and R4 settings
    for (int t = 0; t < 6; t++) begin
      setcfg(int'($urandom_range(60)), int'($urandom_range(15)), int'($urandom_range(15)),
             1'($urandom_range(1)), 1'($urandom_range(1)), 1'($urandom_range(1)),
             int'($urandom_range(15)));
      for (int k = 0; k < 4; k++) add_line(1 + int'($urandom_range(60)), int'($urandom_range(3)));
      drive("R3/R4 random", int'($urandom_range(40)), int'($urandom_range(40)), 0);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule